// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces horizontal sync, vertical sync, data enable and the active-area pixel coordinates for a raster display. Software describes a mode through a small write port. On each axis it gives the position where sync ends, the period, and where the active area starts and ends. All four are counted from the start of sync, so the generator needs only comparators against a running counter. A polarity word sets the sense of each sync and of data enable, and it also carries a clock-inversion flag for the pixel-clock logic outside this block.

Every write lands in a shadow copy. A commit write marks the shadow as ready, and the whole set moves into the live copy on the clock edge that brings the counters back to the frame origin. The outputs therefore never show a mix of old and new settings. The same shadow path also carries a standby switch and a one-of-four output-port select. Standby holds every output at its inactive level and turns all port enables off.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the block is in standby, port enables are 0, the commit flag is 0, the polarity word is 0 (hsync_o=1, vsync_o=1, de_o=0), pclk_inv_o=0, x_o=0 and y_o=0.
- R2: With live horizontal total HT>0, the horizontal counter steps 0,1,…,HT-1 and then returns to 0. The vertical counter advances when the horizontal counter wraps, and it returns to 0 after VT-1.
- R3: Raw hsync is active while the horizontal count is below the sync-end value (address 0). Raw vsync is active while the line count is below the vertical sync-end value (address 4).
- R4: Raw data enable is active when HAS ≤ h < HAE and VAS ≤ v < VAE (addresses 2, 3, 6, 7). In that region x_o=h-HAS and y_o=v-VAS; elsewhere both are 0.
- R5: Polarity word (address 8): bit 0 set makes hsync active-high, bit 1 set makes vsync active-high, and bit 2 set makes data enable active-low. A cleared bit gives the opposite sense.
- R6: Writes to addresses 0–10 change only the shadow copy. Writing 1 in bit 0 at address 15 sets pending_o one edge later. The shadow then becomes live on the edge whose next counter state is h=0, v=0, and pending_o clears on that same edge. Before that edge, a written value has no effect on any output.
- R7: A live horizontal total of 0 (address 1) holds both counters at 0. A live vertical total of 0 (address 5) holds only the vertical counter at 0.
- R8: Standby (address 9, bit 0; 1 = standby) drives hsync_o, vsync_o and de_o to their inactive levels for the live polarity word, sets x_o and y_o to 0 and sets out_en_o to 0.
- R9: Address 10, bits [1:0]=k, selects port k. Out of standby, out_en_o equals 1<<k, so exactly one bit is set.
- R10: pclk_inv_o follows bit 3 of the live polarity word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | DW (12) | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| pclk_inv_o | output | 1 | Pixel-clock inversion flag |
| x_o | output | HW (12) | Active-area column |
| y_o | output | VW (12) | Active-area row |
| out_en_o | output | 4 | One-hot output-port enables |
| pending_o | output | 1 | Commit waiting for frame origin |

## Verification
The sync, enable and coordinate outputs are combinational functions of the registered counters and the live settings. Each result therefore belongs to the same cycle as the counter state, and the bench samples it at the falling edge after the rising edge that produced that state. pending_o rises one edge after the commit write and falls on the edge that loads the new settings. The bench takes the first falling edge with pending_o low as frame cycle 0 and then predicts every later cycle by modular arithmetic on a cycle count it keeps itself. Writes without a commit are checked against the old model over whole frames.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_HSE    = 4'd0;
    localparam logic [ADDR_W-1:0] A_HTOT   = 4'd1;
    localparam logic [ADDR_W-1:0] A_HAS    = 4'd2;
    localparam logic [ADDR_W-1:0] A_HAE    = 4'd3;
    localparam logic [ADDR_W-1:0] A_VSE    = 4'd4;
    localparam logic [ADDR_W-1:0] A_VTOT   = 4'd5;
    localparam logic [ADDR_W-1:0] A_VAS    = 4'd6;
    localparam logic [ADDR_W-1:0] A_VAE    = 4'd7;
    localparam logic [ADDR_W-1:0] A_POL    = 4'd8;
    localparam logic [ADDR_W-1:0] A_STBY   = 4'd9;
    localparam logic [ADDR_W-1:0] A_PORT   = 4'd10;
    localparam logic [ADDR_W-1:0] A_COMMIT = 4'd15;

    localparam int unsigned POL_W  = 4;
    localparam int unsigned PORT_N = 4;
    localparam int unsigned POL_HS = 0;
    localparam int unsigned POL_VS = 1;
    localparam int unsigned POL_DE = 2;
    localparam int unsigned POL_CK = 3;
endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow
    import rtg_pkg::*;
#(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 12,
    parameter int unsigned DW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              frame_next_i,
    output logic [HW-1:0]     hse_o,
    output logic [HW-1:0]     ht_o,
    output logic [HW-1:0]     has_o,
    output logic [HW-1:0]     hae_o,
    output logic [VW-1:0]     vse_o,
    output logic [VW-1:0]     vt_o,
    output logic [VW-1:0]     vas_o,
    output logic [VW-1:0]     vae_o,
    output logic [POL_W-1:0]  pol_o,
    output logic              stby_o,
    output logic [PORT_N-1:0] sel_o,
    output logic              pending_o
);
    localparam int unsigned SELB = $clog2(PORT_N);

    typedef struct packed {
        logic [HW-1:0]     hse;
        logic [HW-1:0]     ht;
        logic [HW-1:0]     has;
        logic [HW-1:0]     hae;
        logic [VW-1:0]     vse;
        logic [VW-1:0]     vt;
        logic [VW-1:0]     vas;
        logic [VW-1:0]     vae;
        logic [POL_W-1:0]  pol;
        logic              stby;
        logic [PORT_N-1:0] sel;
    } cfg_t;

    typedef struct packed {
        cfg_t shd;
        cfg_t act;
        logic pend;
    } st_t;

    localparam cfg_t CFG_RST = '{hse: '0, ht: '0, has: '0, hae: '0,
                                 vse: '0, vt: '0, vas: '0, vae: '0,
                                 pol: '0, stby: 1'b1,
                                 sel: PORT_N'(1)};

    st_t  s_q, s_d;
    logic commit_d;
    logic xfer_d;

    always_comb begin
        s_d      = s_q;
        commit_d = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                A_HSE:    s_d.shd.hse  = wr_data[HW-1:0];
                A_HTOT:   s_d.shd.ht   = wr_data[HW-1:0];
                A_HAS:    s_d.shd.has  = wr_data[HW-1:0];
                A_HAE:    s_d.shd.hae  = wr_data[HW-1:0];
                A_VSE:    s_d.shd.vse  = wr_data[VW-1:0];
                A_VTOT:   s_d.shd.vt   = wr_data[VW-1:0];
                A_VAS:    s_d.shd.vas  = wr_data[VW-1:0];
                A_VAE:    s_d.shd.vae  = wr_data[VW-1:0];
                A_POL:    s_d.shd.pol  = wr_data[POL_W-1:0];
                A_STBY:   s_d.shd.stby = wr_data[0];
                A_PORT:   s_d.shd.sel  = PORT_N'(1) << wr_data[SELB-1:0];
                A_COMMIT: commit_d     = wr_data[0];
                default:  ;
            endcase
        end
        xfer_d = s_q.pend & frame_next_i;
        if (xfer_d) begin
            s_d.act = s_q.shd;
        end
        s_d.pend = commit_d | (s_q.pend & ~xfer_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{shd: CFG_RST, act: CFG_RST, pend: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign hse_o     = s_q.act.hse;
    assign ht_o      = s_q.act.ht;
    assign has_o     = s_q.act.has;
    assign hae_o     = s_q.act.hae;
    assign vse_o     = s_q.act.vse;
    assign vt_o      = s_q.act.vt;
    assign vas_o     = s_q.act.vas;
    assign vae_o     = s_q.act.vae;
    assign pol_o     = s_q.act.pol;
    assign stby_o    = s_q.act.stby;
    assign sel_o     = s_q.act.sel;
    assign pending_o = s_q.pend;

    // R6
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_next_i |=> $stable(s_q.act));

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && frame_next_i && !(wr_en && wr_addr == A_COMMIT && wr_data[0]))
        |=> !s_q.pend);

    // R9
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.act.sel) == 1);
endmodule

// File: rtl/rtg_raster_cnt.sv
module rtg_raster_cnt #(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] ht_i,
    input  logic [VW-1:0] vt_i,
    output logic [HW-1:0] h_o,
    output logic [VW-1:0] v_o,
    output logic          frame_next_o
);
    localparam logic [HW-1:0] H_ONE = HW'(1);
    localparam logic [VW-1:0] V_ONE = VW'(1);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } cnt_t;

    cnt_t c_q, c_d;
    logic h_last_d;
    logic v_last_d;

    always_comb begin
        c_d      = c_q;
        h_last_d = (ht_i == '0) || (c_q.h >= ht_i - H_ONE);
        v_last_d = (vt_i == '0) || (c_q.v >= vt_i - V_ONE);
        if (ht_i == '0) begin
            c_d.h = '0;
            c_d.v = '0;
        end else if (h_last_d) begin
            c_d.h = '0;
            c_d.v = v_last_d ? '0 : c_q.v + V_ONE;
        end else begin
            c_d.h = c_q.h + H_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign h_o          = c_q.h;
    assign v_o          = c_q.v;
    assign frame_next_o = (c_d.h == '0) && (c_d.v == '0);

    // R2
    h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ht_i != '0) |-> (c_q.h < ht_i));

    // R2
    h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ht_i != '0 && c_q.h != ht_i - H_ONE) |=> (c_q.h == $past(c_q.h) + H_ONE));

    // R7
    h_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ht_i == '0) |=> (c_q.h == '0 && c_q.v == '0));
endmodule

// File: rtl/rtg_pixel_out.sv
module rtg_pixel_out
    import rtg_pkg::*;
#(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 12
) (
    input  logic [HW-1:0]     h_i,
    input  logic [VW-1:0]     v_i,
    input  logic [HW-1:0]     hse_i,
    input  logic [HW-1:0]     has_i,
    input  logic [HW-1:0]     hae_i,
    input  logic [VW-1:0]     vse_i,
    input  logic [VW-1:0]     vas_i,
    input  logic [VW-1:0]     vae_i,
    input  logic [POL_W-1:0]  pol_i,
    input  logic              stby_i,
    input  logic [PORT_N-1:0] sel_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              pclk_inv_o,
    output logic [HW-1:0]     x_o,
    output logic [VW-1:0]     y_o,
    output logic [PORT_N-1:0] out_en_o
);
    logic hs_raw, vs_raw, de_raw;

    always_comb begin
        hs_raw = ~stby_i && (h_i < hse_i);
        vs_raw = ~stby_i && (v_i < vse_i);
        de_raw = ~stby_i && (h_i >= has_i) && (h_i < hae_i)
                         && (v_i >= vas_i) && (v_i < vae_i);

        hsync_o    = pol_i[POL_HS] ? hs_raw : ~hs_raw;
        vsync_o    = pol_i[POL_VS] ? vs_raw : ~vs_raw;
        de_o       = pol_i[POL_DE] ? ~de_raw : de_raw;
        pclk_inv_o = pol_i[POL_CK];

        x_o      = de_raw ? h_i - has_i : '0;
        y_o      = de_raw ? v_i - vas_i : '0;
        out_en_o = stby_i ? '0 : sel_i;
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 12,
    localparam int unsigned DW = (HW > VW) ? HW : VW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              pclk_inv_o,
    output logic [HW-1:0]     x_o,
    output logic [VW-1:0]     y_o,
    output logic [PORT_N-1:0] out_en_o,
    output logic              pending_o
);
    logic [HW-1:0]     hse, ht, has, hae, h_cnt;
    logic [VW-1:0]     vse, vt, vas, vae, v_cnt;
    logic [POL_W-1:0]  pol;
    logic              stby;
    logic [PORT_N-1:0] sel;
    logic              frame_next;

    rtg_shadow #(.HW(HW), .VW(VW), .DW(DW)) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_next_i(frame_next),
        .hse_o(hse), .ht_o(ht), .has_o(has), .hae_o(hae),
        .vse_o(vse), .vt_o(vt), .vas_o(vas), .vae_o(vae),
        .pol_o(pol), .stby_o(stby), .sel_o(sel), .pending_o(pending_o)
    );

    rtg_raster_cnt #(.HW(HW), .VW(VW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .ht_i(ht), .vt_i(vt),
        .h_o(h_cnt), .v_o(v_cnt), .frame_next_o(frame_next)
    );

    rtg_pixel_out #(.HW(HW), .VW(VW)) u_out (
        .h_i(h_cnt), .v_i(v_cnt),
        .hse_i(hse), .has_i(has), .hae_i(hae),
        .vse_i(vse), .vas_i(vas), .vae_i(vae),
        .pol_i(pol), .stby_i(stby), .sel_i(sel),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .pclk_inv_o(pclk_inv_o), .x_o(x_o), .y_o(y_o),
        .out_en_o(out_en_o)
    );

    // R8
    stby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stby |-> (de_o == pol[POL_DE] && out_en_o == '0
                  && hsync_o == ~pol[POL_HS] && vsync_o == ~pol[POL_VS]));

    // R4
    xy_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o == pol[POL_DE]) |-> (x_o == '0 && y_o == '0));

    // R4
    x_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o != pol[POL_DE]) |-> (x_o < hae - has && h_cnt < ht));
endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        hsync_o, vsync_o, de_o, pclk_inv_o, pending_o;
    logic [11:0] x_o, y_o;
    logic [3:0]  out_en_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    raster_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .pclk_inv_o(pclk_inv_o), .x_o(x_o), .y_o(y_o),
        .out_en_o(out_en_o), .pending_o(pending_o)
    );

    typedef struct packed {
        logic [11:0] hse, ht, has, hae, vse, vt, vas, vae;
        logic [3:0]  pol;
        logic [1:0]  sel;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{12'd2, 12'd10, 12'd3, 12'd8,  12'd1, 12'd6, 12'd2, 12'd5, 4'b0011, 2'd2},
        '{12'd1, 12'd7,  12'd2, 12'd6,  12'd2, 12'd5, 12'd3, 12'd4, 4'b0100, 2'd0},
        '{12'd3, 12'd12, 12'd4, 12'd11, 12'd1, 12'd4, 12'd1, 12'd3, 4'b1010, 2'd3},
        '{12'd2, 12'd0,  12'd1, 12'd4,  12'd1, 12'd5, 12'd0, 12'd3, 4'b0000, 2'd1},
        '{12'd2, 12'd6,  12'd2, 12'd5,  12'd1, 12'd0, 12'd0, 12'd3, 4'b0001, 2'd1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [11:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int frame_len(input vec_t c);
        int hl = (c.ht == 0) ? 1 : int'(c.ht);
        int vl = (c.vt == 0) ? 1 : int'(c.vt);
        return hl * vl + hl + 4;
    endfunction

    task automatic check_cycle(input vec_t c, input logic stby, input int t);
        int  h, v;
        logic hs, vs, de;
        h  = (c.ht == 0) ? 0 : t % int'(c.ht);
        v  = (c.ht == 0 || c.vt == 0) ? 0 : (t / int'(c.ht)) % int'(c.vt);
        hs = !stby && h < int'(c.hse);
        vs = !stby && v < int'(c.vse);
        de = !stby && h >= int'(c.has) && h < int'(c.hae)
                   && v >= int'(c.vas) && v < int'(c.vae);
        chk("R3 R5 hsync", int'(hsync_o), int'(c.pol[0] ? hs : !hs));
        chk("R3 R5 vsync", int'(vsync_o), int'(c.pol[1] ? vs : !vs));
        chk("R4 R5 de",    int'(de_o),    int'(c.pol[2] ? !de : de));
        chk("R2 R4 x",     int'(x_o),     de ? h - int'(c.has) : 0);
        chk("R2 R4 y",     int'(y_o),     de ? v - int'(c.vas) : 0);
    endtask

    task automatic load(input vec_t c, input logic stby);
        wr(4'd0, c.hse); wr(4'd1, c.ht); wr(4'd2, c.has); wr(4'd3, c.hae);
        wr(4'd4, c.vse); wr(4'd5, c.vt); wr(4'd6, c.vas); wr(4'd7, c.vae);
        wr(4'd8, {8'd0, c.pol}); wr(4'd9, {11'd0, stby});
        wr(4'd10, {10'd0, c.sel});
    endtask

    task automatic commit_and_wait();
        wr(4'd15, 12'd1);
        chk("R6 pending set", int'(pending_o), 1);
        while (pending_o) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        vec_t c;
        int   t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 hsync",    int'(hsync_o),    1);
        chk("R1 vsync",    int'(vsync_o),    1);
        chk("R1 de",       int'(de_o),       0);
        chk("R1 x",        int'(x_o),        0);
        chk("R1 y",        int'(y_o),        0);
        chk("R1 out_en",   int'(out_en_o),   0);
        chk("R1 pending",  int'(pending_o),  0);
        chk("R1 pclk_inv", int'(pclk_inv_o), 0);

        // Vector table: each mode checked over a frame plus wrap
        for (int i = 0; i < NV; i++) begin
            c = VECS[i];
            load(c, 1'b0);
            commit_and_wait();
            chk("R9 out_en",      int'(out_en_o),   1 << c.sel);
            chk("R10 pclk_inv",   int'(pclk_inv_o), int'(c.pol[3]));
            chk("R6 R7 pending",  int'(pending_o),  0);
            for (int k = 0; k < frame_len(c); k++) begin
                if (k != 0) @(negedge clk);
                check_cycle(c, 1'b0, k);
            end
        end

        // R6 writes without commit have no effect; C4 timing still running
        c = VECS[NV-1];
        t = frame_len(c) - 1;
        wr(4'd0, 12'd4);   t++; check_cycle(c, 1'b0, t);
        wr(4'd8, 12'd6);   t++; check_cycle(c, 1'b0, t);
        for (int k = 0; k < 14; k++) begin
            @(negedge clk); t++;
            check_cycle(c, 1'b0, t);
        end
        chk("R6 pending idle", int'(pending_o), 0);

        // R8 standby: held writes (hse=4, pol=0110) become live with it
        c.hse = 12'd4;
        c.pol = 4'b0110;
        wr(4'd9, 12'd1);
        commit_and_wait();
        for (int k = 0; k < 10; k++) begin
            if (k != 0) @(negedge clk);
            chk("R8 hsync idle", int'(hsync_o), 1);
            chk("R8 vsync idle", int'(vsync_o), 0);
            chk("R8 de idle",    int'(de_o),    1);
            chk("R8 x",          int'(x_o),     0);
            chk("R8 y",          int'(y_o),     0);
            chk("R8 out_en",     int'(out_en_o), 0);
        end

        // Leave standby; held settings now drive outputs
        wr(4'd9, 12'd0);
        commit_and_wait();
        chk("R9 out_en resume", int'(out_en_o), 1 << c.sel);
        for (int k = 0; k < frame_len(c); k++) begin
            if (k != 0) @(negedge clk);
            check_cycle(c, 1'b0, k);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule